// File: doc/BRIEF.md
# DSP Peripheral Register and Interrupt Controller

This block sits on the peripheral bus of a 24-bit DSP core and answers accesses to the top of its I/O address space. It holds a pending-interrupt register. A frame-start event sets a bit in that register, and software clears bits by writing ones. A DMA end-of-list flag is kept apart from the register and is merged into the status word whenever it is read.

A write to the idle-request address puts the core into idle. A separate wake input releases it. Four addresses are forwarded to an external DMA controller, giving it a register select, a write strobe, write data and a read-back path.

The block also watches the DMA RUNNING status. Once that status has been seen for three retired instructions, the block emits a one-cycle stop strobe, and the controller uses it to clear RUNNING and set STOPPED.

Top module: `dsp_periph_ctrl`

## Requirements
- R1: After reset, `bus_rdata`, `idle`, the pending-interrupt bits and the end-of-list flag are all zero, and `dma_stop` is low.
- R2: A write to 0xFFFFC4 with bit 0 set raises `idle` on the next cycle. Bits 23..1 of that write have no effect, and a write with bit 0 clear leaves `idle` unchanged. `wake` clears `idle`. If both happen in the same cycle, the write wins.
- R3: A `frame_start` pulse sets bit 1 (start frame) of the pending-interrupt register.
- R4: A read of 0xFFFFC5 returns the pending-interrupt register, with bit 7 (DMA end-of-list) forced high while the end-of-list flag is set. A `dma_eol` pulse sets that flag.
- R5: A write to 0xFFFFC5 clears each pending bit that is one in the written value. If bit 7 of the write is set, the end-of-list flag is also cleared.
- R6: When a set event and a clearing write hit the same bit in the same cycle, the bit ends up set. This applies to `frame_start` against bit 1 and to `dma_eol` against bit 7.
- R7: Addresses 0xFFFFD4, 0xFFFFD5, 0xFFFFD6 and 0xFFFFD7 drive `dma_sel` to 0, 1, 2 and 3 respectively (next block, start block, control, configuration). Writes raise `dma_wr` with `dma_wdata` equal to the bus data. Reads return `dma_rdata`.
- R8: A read of 0xFFFFB3 returns zero. A read of any other address not named in R4 or R7 returns 0xABABA.
- R9: Read data appears on `bus_rdata` one cycle after `bus_rd` and holds until the next read.
- R10: While `dma_running` is high, `dma_stop` is raised together with every third `instr_retired` pulse, and the count then restarts. The count is cleared whenever `dma_running` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 24 | Peripheral address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 24 | Write data |
| bus_rdata | output | 24 | Registered read data |
| frame_start | input | 1 | Start-of-frame event pulse |
| dma_eol | input | 1 | DMA end-of-list event pulse |
| wake | input | 1 | Releases the idle state |
| idle | output | 1 | Core idle request |
| instr_retired | input | 1 | One pulse per executed instruction |
| dma_running | input | 1 | DMA control RUNNING status |
| dma_stop | output | 1 | Strobe: clear RUNNING, set STOPPED |
| dma_sel | output | 2 | DMA register select |
| dma_wr | output | 1 | DMA register write strobe |
| dma_wdata | output | 24 | DMA register write data |
| dma_rdata | input | 24 | DMA register read data for `dma_sel` |

## Verification
The clear path is swept over all 256 low-byte write masks, each applied after both the start-frame event and the end-of-list event. This separates the bits that are cleared from those that survive, and it separates the flag held outside the register from the register itself.

The read decoder is swept over the 128 top addresses. This shows whether the zero address, the status address, the DMA window and the 0xABABA default are each decoded at the right place.

Idle writes are tried with values that differ only in bits 0 to 3, which shows whether bit 0 alone decides the outcome. The stop timer is driven with retire pulses spaced at different intervals and with the running status toggled, which distinguishes counting cycles from counting instructions.

// File: rtl/dsp_periph_ctrl.sv
module dsp_periph_ctrl #(
  parameter int DW = 24,
  parameter int AW = 24,
  parameter int STOP_AFTER = 3,
  parameter logic [AW-1:0] A_ZERO = 24'hFFFFB3,
  parameter logic [AW-1:0] A_IDLE = 24'hFFFFC4,
  parameter logic [AW-1:0] A_IRQ  = 24'hFFFFC5,
  parameter logic [AW-1:0] A_DMA  = 24'hFFFFD4,
  parameter logic [DW-1:0] FILL   = 24'hABABA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          frame_start,
  input  logic          dma_eol,
  input  logic          wake,
  output logic          idle,
  input  logic          instr_retired,
  input  logic          dma_running,
  output logic          dma_stop,
  output logic [1:0]    dma_sel,
  output logic          dma_wr,
  output logic [DW-1:0] dma_wdata,
  input  logic [DW-1:0] dma_rdata
);
  localparam int CW = $clog2(STOP_AFTER + 1);
  localparam int BIT_FRAME = 1;
  localparam int BIT_EOL = 7;

  logic [DW-1:0] pend;
  logic          eol_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] set_vec;
  logic [DW-1:0] clr_vec;

  wire hit_idle = bus_addr == A_IDLE;
  wire hit_irq  = bus_addr == A_IRQ;
  wire hit_dma  = bus_addr[AW-1:2] == A_DMA[AW-1:2];
  wire idle_req = bus_wr && hit_idle && bus_wdata[0];
  wire irq_clr  = bus_wr && hit_irq;

  assign set_vec   = frame_start ? (DW'(1) << BIT_FRAME) : '0;
  assign clr_vec   = irq_clr ? bus_wdata : '0;
  assign dma_sel   = bus_addr[1:0];
  assign dma_wr    = bus_wr && hit_dma;
  assign dma_wdata = bus_wdata;
  assign dma_stop  = dma_running && instr_retired && cnt == CW'(STOP_AFTER - 1);

  always_comb begin
    if (bus_addr == A_ZERO)
      rd_mux = '0;
    else if (hit_irq)
      rd_mux = pend | (DW'(eol_q) << BIT_EOL);
    else if (hit_dma)
      rd_mux = dma_rdata;
    else
      rd_mux = FILL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend      <= '0;
      eol_q     <= 1'b0;
      idle      <= 1'b0;
      cnt       <= '0;
      bus_rdata <= '0;
    end else begin
      pend <= (pend & ~clr_vec) | set_vec;
      if (dma_eol)
        eol_q <= 1'b1;
      else if (irq_clr && bus_wdata[BIT_EOL])
        eol_q <= 1'b0;
      if (idle_req)
        idle <= 1'b1;
      else if (wake)
        idle <= 1'b0;
      if (!dma_running || dma_stop)
        cnt <= '0;
      else if (instr_retired)
        cnt <= cnt + 1'b1;
      if (bus_rd)
        bus_rdata <= rd_mux;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (bus_rdata == '0 && !idle && !eol_q && pend == '0));

  assert_idle_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_IDLE && bus_wdata[0]) |=> idle);

  assert_idle_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wake && !bus_wr) |=> !idle);

  assert_frame_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> pend[BIT_FRAME]);

  assert_eol_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_IRQ && bus_wdata[BIT_EOL] && !dma_eol) |=> !eol_q);

  assert_eol_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dma_eol |=> eol_q);

  assert_dma_ctrl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 24'hFFFFD6) |-> (dma_wr && dma_sel == 2'd2));

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  assert_stop_cause_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |-> (dma_running && instr_retired));

  assert_stop_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_stop |=> !dma_stop);
endmodule

// File: tb/sim_dsp_periph_ctrl.sv
module sim_dsp_periph_ctrl;
  logic clk = 0;
  logic rst_n = 0;
  logic [23:0] bus_addr = 0, bus_wdata = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [23:0] bus_rdata;
  logic frame_start = 0, dma_eol = 0, wake = 0, instr_retired = 0;
  logic idle, dma_stop, dma_wr;
  logic [1:0] dma_sel;
  logic [23:0] dma_wdata, dma_rdata;
  logic [23:0] dreg [4];
  logic dma_running;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  assign dma_rdata = dreg[dma_sel];
  assign dma_running = dreg[2][0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) dreg[i] <= 24'h0;
    end else begin
      if (dma_wr) dreg[dma_sel] <= dma_wdata;
      if (dma_stop) begin
        dreg[2][0] <= 1'b0;
        dreg[2][1] <= 1'b1;
      end
    end
  end

  dsp_periph_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_start(frame_start),
    .dma_eol(dma_eol), .wake(wake), .idle(idle), .instr_retired(instr_retired),
    .dma_running(dma_running), .dma_stop(dma_stop), .dma_sel(dma_sel),
    .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata));

  task automatic chk(input string r, input logic [23:0] act, input logic [23:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %06h expected %06h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [23:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [23:0] a, output logic [23:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  task automatic pulse_frame_eol(input bit f, input bit e);
    @(negedge clk);
    frame_start = f; dma_eol = e;
    @(negedge clk);
    frame_start = 0; dma_eol = 0;
  endtask

  task automatic retire(input logic exp_stop, input int gap);
    @(negedge clk);
    instr_retired = 1;
    #1;
    chk("R10 stop strobe", {23'h0, dma_stop}, {23'h0, exp_stop});
    @(negedge clk);
    instr_retired = 0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [23:0] v, e;
    repeat (3) @(negedge clk);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 idle", {23'h0, idle}, 0);
    chk("R1 stop", {23'h0, dma_stop}, 0);
    rst_n = 1;
    rd(24'hFFFFC5, v);
    chk("R1 status", v, 0);

    // R2: only bit 0 of the idle write matters
    for (int p = 0; p < 16; p++) begin
      wr(24'hFFFFC4, 24'(p) | 24'hABC0);
      chk("R2 idle write", {23'h0, idle}, {23'h0, p[0]});
      @(negedge clk); wake = 1; @(negedge clk); wake = 0;
      chk("R2 wake", {23'h0, idle}, 0);
    end
    @(negedge clk);
    bus_addr = 24'hFFFFC4; bus_wdata = 1; bus_wr = 1; wake = 1;
    @(negedge clk);
    bus_wr = 0; wake = 0;
    chk("R2 write beats wake", {23'h0, idle}, 1);
    @(negedge clk); wake = 1; @(negedge clk); wake = 0;

    // R3 R4 R5: sweep clear masks
    for (int m = 0; m < 256; m++) begin
      pulse_frame_eol(1, 1);
      rd(24'hFFFFC5, v);
      chk("R3 R4 status set", v, 24'h82);
      wr(24'hFFFFC5, 24'(m));
      rd(24'hFFFFC5, v);
      e = ((m[1] ? 24'h0 : 24'h2) | (m[7] ? 24'h0 : 24'h80));
      chk("R5 w1c", v, e);
      wr(24'hFFFFC5, 24'hFFFFFF);
    end
    pulse_frame_eol(0, 1);
    rd(24'hFFFFC5, v);
    chk("R4 eol only", v, 24'h80);
    wr(24'hFFFFC5, 24'h000002);
    rd(24'hFFFFC5, v);
    chk("R5 bit7 clear keeps eol", v, 24'h80);
    wr(24'hFFFFC5, 24'h80);

    // R6: set wins
    @(negedge clk);
    bus_addr = 24'hFFFFC5; bus_wdata = 24'hFFFFFF; bus_wr = 1;
    frame_start = 1; dma_eol = 1;
    @(negedge clk);
    bus_wr = 0; frame_start = 0; dma_eol = 0;
    rd(24'hFFFFC5, v);
    chk("R6 set wins", v, 24'h82);
    wr(24'hFFFFC5, 24'hFFFFFF);

    // R7: DMA window
    for (int i = 0; i < 4; i++) wr(24'hFFFFD4 + 24'(i), 24'h100000 * 24'(i + 1) + 24'h0A0);
    for (int i = 0; i < 4; i++) begin
      chk("R7 dma write", dreg[i], 24'h100000 * 24'(i + 1) + 24'h0A0);
      rd(24'hFFFFD4 + 24'(i), v);
      chk("R7 dma read", v, 24'h100000 * 24'(i + 1) + 24'h0A0);
    end
    wr(24'hFFFFD6, 24'h0);

    // R8: read decode sweep
    pulse_frame_eol(1, 0);
    for (int a = 24'hFFFF80; a <= 24'hFFFFFF; a++) begin
      rd(24'(a), v);
      if (a == 24'hFFFFB3) e = 0;
      else if (a == 24'hFFFFC5) e = 24'h2;
      else if (a >= 24'hFFFFD4 && a <= 24'hFFFFD7) e = dreg[a - 24'hFFFFD4];
      else e = 24'hABABA;
      chk("R8 decode", v, e);
    end

    // R9: hold between reads
    rd(24'hFFFFB3, v);
    repeat (3) @(negedge clk);
    chk("R9 hold", bus_rdata, 0);
    rd(24'hFFFFC0, v);
    chk("R9 latency", bus_rdata, 24'hABABA);

    // R10: stop timer
    for (int g = 0; g < 3; g++) begin
      wr(24'hFFFFD6, 24'h1);
      retire(0, g);
      retire(0, g);
      rd(24'hFFFFD6, v);
      chk("R10 still running", v, 24'h1);
      retire(1, g);
      rd(24'hFFFFD6, v);
      chk("R10 stopped", v, 24'h2);
      retire(0, g);
    end
    wr(24'hFFFFD6, 24'h1);
    retire(0, 0);
    retire(0, 0);
    wr(24'hFFFFD6, 24'h0);
    retire(0, 0);
    wr(24'hFFFFD6, 24'h1);
    retire(0, 0);
    retire(0, 0);
    retire(1, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule